// File: doc/BRIEF.md
# Tagged-Word Transmit Frame Packer

This block turns an outgoing Ethernet frame, presented as a byte stream, into a sequence of 18-bit tagged words for a transmit FIFO. Each word holds 16 bits of data and a 2-bit tag. The tag tells the consumer what the data holds: two packed payload bytes, a trailing lone byte, a status word, or an out-of-band word.

A frame begins with a start handshake. The handshake carries the frame length, a flag that requests out-of-band words, and a 16-bit frame identifier. The packer first emits a status word. It then packs the payload bytes two at a time. Frames shorter than the minimum are padded with zeros. A final lone byte gets its own tag. If out-of-band words were requested, a fixed marker word and then the identifier follow the payload.

Both the byte input and the word output use valid/ready handshakes. The output is a registered single-word stage.

Top module: `tx_word_packer`

## Requirements
- R1: Each output word carries its data in bits 15:0 and its tag in bits 17:16. The tag codes are 0 for packed data, 1 for out-of-band, 2 for status and 3 for a lone final byte.
- R2: The first word of every frame is a status word (tag 2) with data 0x0000.
- R3: Two consecutive payload bytes share one tag-0 word. The earlier byte is in bits 15:8 and the later byte is in bits 7:0.
- R4: A frame whose length is below 60 bytes is emitted as 60 bytes. The missing bytes are zero, and exactly the stated number of bytes is taken from the input.
- R5: When the effective length is odd, the final byte is emitted alone in a tag-3 word. The byte is in bits 15:8 and bits 7:0 are zero.
- R6: When out-of-band words are requested, two tag-1 words follow the payload: first 0x1000, then the frame identifier. Without the request, no tag-1 word is emitted.
- R7: While out_ready is low, a valid output word stays valid and unchanged, so no word is lost or repeated.
- R8: start_ready is high only when the packer is idle and its output register is empty. No new frame is accepted while any word of the previous frame has not yet been handed off.
- R9: A frame of even length of at least 60 bytes yields the status word followed by exactly length/2 data words and nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Frame start request |
| start_ready | output | 1 | Start accepted when high with start_valid |
| start_len | input | LEN_W | Frame length in bytes |
| start_oob | input | 1 | Append out-of-band words |
| start_id | input | 16 | Frame identifier for the second out-of-band word |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Payload byte taken |
| in_byte | input | 8 | Payload byte |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_word | output | 18 | Tag in 17:16, data in 15:0 |

## Verification
On every cycle the assertions check the following:
- Status words carry zero data.
- Lone-byte words have an empty low byte.
- The first out-of-band word of a run carries the marker.
- A stalled output word holds its value.
- A start is never accepted while a word is pending.
- Every frame handed off before its out-of-band words or before the next status word carried at least the minimum byte count.

Only the directed scenarios can show the following:
- The exact byte order.
- That padding bytes are zero.
- That padding takes no bytes from the input.
- That a lone-byte word appears exactly when the effective length is odd.
- That the identifier lands in the second out-of-band word.

// File: rtl/pkr_pkg.sv
package pkr_pkg;
  typedef enum logic [1:0] {
    TAG_DATA  = 2'd0,
    TAG_OOB   = 2'd1,
    TAG_STAT  = 2'd2,
    TAG_LAST1 = 2'd3
  } tag_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STAT,
    ST_HI,
    ST_LO,
    ST_OOB0,
    ST_OOB1
  } pk_state_e;

  localparam logic [15:0] OOB_MARKER = 16'h1000;
  localparam int          WORD_W     = 18;
endpackage

// File: rtl/pkr_len_fix.sv
module pkr_len_fix #(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 60
) (
  input  logic [LEN_W-1:0] raw_len,
  output logic [LEN_W-1:0] eff_len
);
  localparam logic [LEN_W-1:0] MIN_V = LEN_W'(MIN_LEN);

  always_comb begin
    eff_len = (raw_len < MIN_V) ? MIN_V : raw_len;
  end
endmodule

// File: rtl/pkr_byte_sel.sv
module pkr_byte_sel #(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0] idx,
  input  logic [LEN_W-1:0] raw_len,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             from_input,
  output logic             byte_ok,
  output logic [7:0]       byte_val
);
  always_comb begin
    from_input = (idx < raw_len);
    byte_ok    = from_input ? in_valid : 1'b1;
    byte_val   = from_input ? in_byte : 8'h00;
  end
endmodule

// File: rtl/pkr_out_stage.sv
module pkr_out_stage #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         can_load,
  output logic         valid,
  output logic [W-1:0] dout
);
  always_comb begin
    can_load = !valid || ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_word_packer.sv
module tx_word_packer
  import pkr_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 60
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_valid,
  output logic             start_ready,
  input  logic [LEN_W-1:0] start_len,
  input  logic             start_oob,
  input  logic [15:0]      start_id,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_byte,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [17:0]      out_word
);
  pk_state_e        st, st_nx;
  logic [LEN_W-1:0] len_q, eff_q, idx;
  logic [LEN_W-1:0] eff_new;
  logic             oob_q;
  logic [15:0]      id_q;
  logic [7:0]       hi_q;

  logic             can_ld, ld;
  logic [WORD_W-1:0] word_nx;
  logic             from_input, byte_ok;
  logic [7:0]       byte_val;
  logic             last_pos, hi_slot, lo_slot, adv;
  logic             start_fire;

  pkr_len_fix #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_len (
    .raw_len (start_len),
    .eff_len (eff_new)
  );

  pkr_byte_sel #(.LEN_W(LEN_W)) u_sel (
    .idx        (idx),
    .raw_len    (len_q),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .from_input (from_input),
    .byte_ok    (byte_ok),
    .byte_val   (byte_val)
  );

  pkr_out_stage #(.W(WORD_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .din      (word_nx),
    .ready    (out_ready),
    .can_load (can_ld),
    .valid    (out_valid),
    .dout     (out_word)
  );

  always_comb begin
    start_ready = (st == ST_IDLE) && !out_valid;
    start_fire  = start_valid && start_ready;
    last_pos    = (idx == (eff_q - LEN_W'(1)));
    hi_slot     = (st == ST_HI) && (!last_pos || can_ld);
    lo_slot     = (st == ST_LO) && can_ld;
    in_ready    = (hi_slot || lo_slot) && from_input;
    adv         = (hi_slot || lo_slot) && byte_ok;
  end

  always_comb begin
    st_nx   = st;
    ld      = 1'b0;
    word_nx = '0;
    unique case (st)
      ST_IDLE: begin
        if (start_fire) st_nx = ST_STAT;
      end
      ST_STAT: begin
        if (can_ld) begin
          ld      = 1'b1;
          word_nx = {TAG_STAT, 16'h0000};
          st_nx   = ST_HI;
        end
      end
      ST_HI: begin
        if (adv) begin
          if (last_pos) begin
            ld      = 1'b1;
            word_nx = {TAG_LAST1, byte_val, 8'h00};
            st_nx   = oob_q ? ST_OOB0 : ST_IDLE;
          end else begin
            st_nx = ST_LO;
          end
        end
      end
      ST_LO: begin
        if (adv) begin
          ld      = 1'b1;
          word_nx = {TAG_DATA, hi_q, byte_val};
          st_nx   = last_pos ? (oob_q ? ST_OOB0 : ST_IDLE) : ST_HI;
        end
      end
      ST_OOB0: begin
        if (can_ld) begin
          ld      = 1'b1;
          word_nx = {TAG_OOB, OOB_MARKER};
          st_nx   = ST_OOB1;
        end
      end
      ST_OOB1: begin
        if (can_ld) begin
          ld      = 1'b1;
          word_nx = {TAG_OOB, id_q};
          st_nx   = ST_IDLE;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      len_q <= '0;
      eff_q <= LEN_W'(MIN_LEN);
      oob_q <= 1'b0;
      id_q  <= '0;
      idx   <= '0;
      hi_q  <= '0;
    end else begin
      st <= st_nx;
      if (start_fire) begin
        len_q <= start_len;
        eff_q <= eff_new;
        oob_q <= start_oob;
        id_q  <= start_id;
        idx   <= '0;
      end else if (adv) begin
        idx <= idx + LEN_W'(1);
      end
      if (st == ST_HI && adv && !last_pos) hi_q <= byte_val;
    end
  end
endmodule

// File: rtl/tx_word_packer_chk.sv
module tx_word_packer_chk #(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 60
) (
  input logic        clk,
  input logic        rst,
  input logic        start_valid,
  input logic        start_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [17:0] out_word
);
  logic [LEN_W:0] byte_cnt;
  logic           prev_oob;
  logic           seen;
  logic [1:0]     tag;
  logic           hand;

  always_comb begin
    tag  = out_word[17:16];
    hand = out_valid && out_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_cnt <= '0;
      prev_oob <= 1'b0;
      seen     <= 1'b0;
    end else if (hand) begin
      prev_oob <= (tag == 2'd1);
      case (tag)
        2'd2: begin
          byte_cnt <= '0;
          seen     <= 1'b1;
        end
        2'd0: byte_cnt <= byte_cnt + (LEN_W+1)'(2);
        2'd3: byte_cnt <= byte_cnt + (LEN_W+1)'(1);
        default: ;
      endcase
    end
  end

  AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid && tag == 2'd2 |-> out_word[15:0] == 16'h0000); // R2

  AST_SINGLE_LOW: assert property (@(posedge clk) disable iff (rst)
    out_valid && tag == 2'd3 |-> out_word[7:0] == 8'h00); // R5

  AST_OOB_MARKER: assert property (@(posedge clk) disable iff (rst)
    out_valid && tag == 2'd1 && !prev_oob |-> out_word[15:0] == 16'h1000); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_word)); // R7

  AST_START_EMPTY: assert property (@(posedge clk) disable iff (rst)
    start_valid && start_ready |-> !out_valid); // R8

  AST_PAD_BEFORE_OOB: assert property (@(posedge clk) disable iff (rst)
    hand && tag == 2'd1 && !prev_oob |-> byte_cnt >= (LEN_W+1)'(MIN_LEN)); // R4

  AST_PAD_BEFORE_NEXT: assert property (@(posedge clk) disable iff (rst)
    hand && tag == 2'd2 && seen |-> byte_cnt >= (LEN_W+1)'(MIN_LEN)); // R4
endmodule

bind tx_word_packer tx_word_packer_chk #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_valid (start_valid),
  .start_ready (start_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_word    (out_word)
);

// File: tb/tx_word_packer_bench.sv
module tx_word_packer_bench;
  localparam int CLK_NS  = 10;
  localparam int LEN_W   = 16;
  localparam int MIN_LEN = 60;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_valid = 1'b0;
  logic             start_ready;
  logic [LEN_W-1:0] start_len = '0;
  logic             start_oob = 1'b0;
  logic [15:0]      start_id = '0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [7:0]       in_byte = '0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [17:0]      out_word;

  int n_chk = 0;
  int n_bad = 0;
  bit rx_done;
  int consumed;
  logic [17:0] exp_q[$];

  always #(CLK_NS/2) clk = ~clk;

  tx_word_packer #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_tx_word_packer (
    .clk(clk), .rst(rst),
    .start_valid(start_valid), .start_ready(start_ready),
    .start_len(start_len), .start_oob(start_oob), .start_id(start_id),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input int i, input int seed);
    return 8'((i * 13 + seed) & 255);
  endfunction

  task automatic build(input int len, input bit oob, input logic [15:0] id, input int seed);
    int eff;
    logic [7:0] hi, lo;
    exp_q.delete();
    exp_q.push_back({2'd2, 16'h0000});
    eff = (len < MIN_LEN) ? MIN_LEN : len;
    for (int i = 0; i < eff; i += 2) begin
      hi = (i < len) ? byte_of(i, seed) : 8'h00;
      if (i + 1 < eff) begin
        lo = (i + 1 < len) ? byte_of(i + 1, seed) : 8'h00;
        exp_q.push_back({2'd0, hi, lo});
      end else begin
        exp_q.push_back({2'd3, hi, 8'h00});
      end
    end
    if (oob) begin
      exp_q.push_back({2'd1, 16'h1000});
      exp_q.push_back({2'd1, id});
    end
  endtask

  function automatic string tag_req(input logic [1:0] t);
    case (t)
      2'd2: return "R1/R2";
      2'd3: return "R1/R5";
      2'd1: return "R1/R6";
      default: return "R1/R3";
    endcase
  endfunction

  task automatic drive_bytes(input int len, input int seed);
    while (!rx_done) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = (consumed < len) ? byte_of(consumed, seed) : 8'hA5;
      #2;
      if (in_valid && in_ready) consumed++;
    end
    in_valid = 1'b0;
  endtask

  task automatic collect(input int mode, input string size_req);
    int got = 0;
    int cyc = 0;
    bit held = 0;
    bit mid_done = 0;
    logic [17:0] held_word = '0;
    while (got < exp_q.size() && cyc < 4000) begin
      @(negedge clk);
      out_ready = (mode == 0) ? 1'b1 : (cyc % 3 == 0);
      cyc++;
      #1;
      if (held) check(out_valid && out_word == held_word, "R7", int'(out_word), int'(held_word));
      held = out_valid && !out_ready;
      held_word = out_word;
      if (out_valid && out_ready) begin
        check(out_word == exp_q[got], tag_req(exp_q[got][17:16]), int'(out_word), int'(exp_q[got]));
        got++;
      end
      if (got == 2 && !mid_done) begin
        mid_done = 1;
        check(start_ready == 1'b0, "R8", int'(start_ready), 0);
      end
    end
    check(got == exp_q.size(), size_req, got, exp_q.size());
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    check(out_valid == 1'b0, size_req, int'(out_valid), 0);
    rx_done = 1;
  endtask

  task automatic run_frame(input int len, input bit oob, input logic [15:0] id,
                           input int seed, input int mode, input string size_req);
    build(len, oob, id, seed);
    consumed = 0;
    rx_done  = 0;
    @(negedge clk);
    start_valid = 1'b1;
    start_len   = LEN_W'(len);
    start_oob   = oob;
    start_id    = id;
    #1;
    while (!start_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    start_valid = 1'b0;
    fork
      drive_bytes(len, seed);
      collect(mode, size_req);
    join
    check(consumed == len, "R4", consumed, len);
    @(negedge clk);
    #1;
    check(start_ready == 1'b1, "R8", int'(start_ready), 1);
  endtask

  task automatic t_reset();
    #1;
    check(out_valid == 1'b0, "R8", int'(out_valid), 0);
    check(start_ready == 1'b1, "R8", int'(start_ready), 1);
    check(in_ready == 1'b0, "R4", int'(in_ready), 0);
  endtask

  task automatic t_even_long();   run_frame(64, 0, 16'h0000, 3, 0, "R9");  endtask
  task automatic t_odd_oob_stall(); run_frame(61, 1, 16'hBEEF, 11, 1, "R5"); endtask
  task automatic t_short_pad();   run_frame(10, 1, 16'h0042, 5, 0, "R4");  endtask
  task automatic t_short_odd();   run_frame(7, 0, 16'h0000, 9, 1, "R4");   endtask
  task automatic t_long_odd();    run_frame(75, 0, 16'h0000, 21, 1, "R5"); endtask
  task automatic t_zero_len();    run_frame(0, 1, 16'h7E01, 1, 0, "R6");   endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired before the scenarios ended");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_even_long();
    t_odd_oob_stall();
    t_short_pad();
    t_short_odd();
    t_long_odd();
    t_zero_len();
    summary();
    $finish;
  end
endmodule